// File: doc/BRIEF.md
# SPI Master Interrupt Register Set

This block holds the interrupt state of a memory-mapped SPI master. It collects four event sources from the serial engine and its FIFOs. A mode fault pulse is latched until software acknowledges it. Three signals are presented live: TX FIFO level at or above a programmable watermark, TX FIFO full, and RX FIFO not empty. Each source can be masked. The unmasked sources are combined into one registered, level-sensitive interrupt line.

Software changes the mask through two write-only ports. One port sets mask bits where the written word has ones. The other clears mask bits where the written word has ones. The current mask can be read at its own read-only offset. The status register acknowledges the latched fault by writing ones back, so the usual handler reads status and writes the same word back. A watermark register sets the TX level threshold.

The bus is a simple single-cycle interface. A write is one cycle with `wr_en` high. Read data is a combinational function of `addr` and the current state.

Top module: `spi_irq_regs`

## Requirements
- R1: After reset the mask reads 0, the latched fault reads 0, the watermark reads 1 and `irq` is low.
- R2: Status reads at byte offset 0x04 with this bit layout: bit 1 = mode fault, bit 2 = TX level at or above watermark, bit 3 = TX full, bit 4 = RX not empty. Bits 0, 5, 6 and all upper bits read 0.
- R3: Writing offset 0x08 sets every mask bit where the written word has a one and leaves the others unchanged. Offset 0x08 reads 0.
- R4: Writing offset 0x0C clears every mask bit where the written word has a one and leaves the others unchanged. Writing 0x7F clears the whole mask. Offset 0x0C reads 0.
- R5: The mask reads at offset 0x10 in bits 6:0, using the status bit layout, with upper bits 0. A write to 0x10 changes nothing.
- R6: A one-cycle `modf_evt` pulse sets status bit 1 from the next cycle on. The bit stays set until a write to 0x04 with bit 1 set clears it. A write to 0x04 with bit 1 clear leaves it set.
- R7: If `modf_evt` is high in the same cycle as a clearing write to status, bit 1 stays set.
- R8: Status bit 2 is live and equals `tx_level >= watermark`. The watermark is written and read at offset 0x28 in its low LVL_W bits.
- R9: Status bits 3 and 4 follow `tx_full` and `rx_nempty` in the same cycle. Writing ones to them at 0x04 has no effect.
- R10: `irq` is high in a cycle exactly when the AND of status and mask in the previous cycle was nonzero.
- R11: Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` (combinational) |
| modf_evt | input | 1 | Mode fault pulse from the serial engine |
| tx_level | input | LVL_W | TX FIFO fill count |
| tx_full | input | 1 | TX FIFO full |
| rx_nempty | input | 1 | RX FIFO not empty |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench targets a mode fault that arrives in the same cycle as its acknowledge. A design that lets the clear win would lose that fault. It probes the watermark compare at level = threshold and at level = threshold − 1. An off-by-one compare flips status bit 2 at exactly one of these points. Enable and disable writes with partial patterns show whether zero bits disturb the mask. Ones written to live status bits must have no effect on them. The interrupt line is checked one cycle after every status or mask change, so a design that drives the line combinationally, or with an extra cycle of delay, is reported.

// File: rtl/spi_irq_regs.sv
module spi_irq_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LVL_W  = 8,
  parameter int NSRC   = 7,
  parameter logic [ADDR_W-1:0] OFS_STAT = 'h04,
  parameter logic [ADDR_W-1:0] OFS_EN   = 'h08,
  parameter logic [ADDR_W-1:0] OFS_DIS  = 'h0C,
  parameter logic [ADDR_W-1:0] OFS_MASK = 'h10,
  parameter logic [ADDR_W-1:0] OFS_WMRK = 'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              modf_evt,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic              tx_full,
  input  logic              rx_nempty,
  output logic              irq
);
  localparam int B_MODF = 1;
  localparam int B_TXOW = 2;
  localparam int B_FULL = 3;
  localparam int B_RXNE = 4;

  logic [NSRC-1:0]  mask_q;
  logic [NSRC-1:0]  stat;
  logic [LVL_W-1:0] wmrk_q;
  logic             modf_q;
  logic             irq_q;

  wire wr_stat = wr_en && (addr == OFS_STAT);
  wire wr_en_r = wr_en && (addr == OFS_EN);
  wire wr_dis  = wr_en && (addr == OFS_DIS);
  wire wr_wmrk = wr_en && (addr == OFS_WMRK);
  wire [NSRC-1:0] wbits = wdata[NSRC-1:0];
  wire tx_ow = (tx_level >= wmrk_q);

  always_comb begin
    stat = '0;
    stat[B_MODF] = modf_q;
    stat[B_TXOW] = tx_ow;
    stat[B_FULL] = tx_full;
    stat[B_RXNE] = rx_nempty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      modf_q <= 1'b0;
      wmrk_q <= LVL_W'(1);
      irq_q  <= 1'b0;
    end else begin
      if (wr_en_r) mask_q <= mask_q | wbits;
      else if (wr_dis) mask_q <= mask_q & ~wbits;
      modf_q <= modf_evt | (modf_q & ~(wr_stat & wdata[B_MODF]));
      if (wr_wmrk) wmrk_q <= wdata[LVL_W-1:0];
      irq_q <= |(stat & mask_q);
    end
  end

  assign irq = irq_q;

  always_comb begin
    rdata = '0;
    if (addr == OFS_STAT)      rdata = DATA_W'(stat);
    else if (addr == OFS_MASK) rdata = DATA_W'(mask_q);
    else if (addr == OFS_WMRK) rdata = DATA_W'(wmrk_q);
  end

  // R3 R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_r || wr_dis) |=> $stable(mask_q));
  // R6
  modf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    modf_evt |=> modf_q);
  // R6
  modf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[B_MODF] && !modf_evt) |=> !modf_q);
  // R10
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq);
  // R4
  dis_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dis && (&wbits)) |=> (mask_q == '0));
endmodule

// File: tb/sim_spi_irq_regs.sv
module sim_spi_irq_regs;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic modf_evt = 0, tx_full = 0, rx_nempty = 0, irq;
  logic [7:0] tx_level = 0;
  int errs = 0, checks = 0;
  bit done = 0;

  logic [6:0] m_mask;
  logic       m_modf;
  logic [7:0] m_wmrk;

  always #2 clk = ~clk;

  spi_irq_regs u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .modf_evt(modf_evt), .tx_level(tx_level), .tx_full(tx_full),
    .rx_nempty(rx_nempty), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] m_stat();
    logic [6:0] s = '0;
    s[1] = m_modf; s[2] = (tx_level >= m_wmrk); s[3] = tx_full; s[4] = rx_nempty;
    return s;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h04: return {25'b0, m_stat()};
      8'h10: return {25'b0, m_mask};
      8'h28: return {24'b0, m_wmrk};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h04: return "R2";
      8'h08: return "R3";
      8'h0C: return "R4";
      8'h10: return "R5";
      8'h28: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic cyc(logic w, logic [7:0] a, logic [31:0] d, logic mf,
                     logic [7:0] lvl, logic fu, logic rn, string tag = "");
    logic exp_irq;
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; modf_evt = mf; tx_level = lvl; tx_full = fu; rx_nempty = rn;
    #1;
    chk((tag == "") ? tag_of(a) : tag, rdata, m_read(a));
    exp_irq = |(m_stat() & m_mask);
    if (w && a == 8'h08) m_mask = m_mask | d[6:0];
    if (w && a == 8'h0C) m_mask = m_mask & ~d[6:0];
    if (w && a == 8'h28) m_wmrk = d[7:0];
    m_modf = mf | (m_modf & ~(w && a == 8'h04 && d[1]));
    @(posedge clk);
    #1;
    chk("R10", {31'b0, irq}, {31'b0, exp_irq});
  endtask

  initial begin
    m_mask = 0; m_modf = 0; m_wmrk = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    #1;
    chk("R1", {31'b0, irq}, 0);
    cyc(0, 8'h10, 0, 0, 0, 0, 0, "R1");
    cyc(0, 8'h28, 0, 0, 0, 0, 0, "R1");
    cyc(0, 8'h04, 0, 0, 0, 0, 0, "R1");
    // R8 watermark boundary
    cyc(1, 8'h28, 5, 0, 0, 0, 0);
    cyc(0, 8'h04, 0, 0, 4, 0, 0, "R8");
    cyc(0, 8'h04, 0, 0, 5, 0, 0, "R8");
    // R3 partial enable, R5 write to mask ignored
    cyc(1, 8'h08, 32'h14, 0, 0, 0, 0);
    cyc(1, 8'h10, 32'h7F, 0, 0, 0, 0, "R5");
    cyc(1, 8'h08, 32'h02, 0, 0, 0, 0, "R3");
    cyc(0, 8'h10, 0, 0, 0, 0, 0, "R3");
    // R9 live bits, ones written to them do nothing
    cyc(0, 8'h04, 0, 0, 0, 1, 1, "R9");
    cyc(1, 8'h04, 32'h18, 0, 0, 1, 1, "R9");
    cyc(0, 8'h04, 0, 0, 0, 1, 1, "R9");
    // R6 latch and acknowledge
    cyc(0, 8'h04, 0, 1, 0, 0, 0, "R6");
    cyc(1, 8'h04, 32'h00, 0, 0, 0, 0, "R6");
    cyc(0, 8'h04, 0, 0, 0, 0, 0, "R6");
    // R7 set beats clear
    cyc(1, 8'h04, 32'h02, 1, 0, 0, 0, "R7");
    cyc(0, 8'h04, 0, 0, 0, 0, 0, "R7");
    cyc(1, 8'h04, 32'h02, 0, 0, 0, 0, "R6");
    cyc(0, 8'h04, 0, 0, 0, 0, 0, "R6");
    // R4 partial and full disable
    cyc(1, 8'h0C, 32'h04, 0, 0, 0, 0);
    cyc(0, 8'h10, 0, 0, 0, 0, 0, "R4");
    cyc(1, 8'h0C, 32'h7F, 0, 9, 1, 1);
    cyc(0, 8'h10, 0, 0, 9, 1, 1, "R4");
    cyc(0, 8'h3C, 0, 0, 9, 1, 1, "R11");
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      logic [31:0] r = $urandom;
      case (r[2:0])
        0: a = 8'h04; 1: a = 8'h08; 2: a = 8'h0C; 3: a = 8'h10;
        4: a = 8'h28; 5: a = 8'h04; 6: a = 8'h10; default: a = {r[15:10], 2'b00};
      endcase
      cyc(r[3] & r[4], a, (a == 8'h28) ? ($urandom % 12) : $urandom,
          (r[7:5] == 0), 8'($urandom % 12), r[8], r[9]);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule